// File: doc/BRIEF.md
# Phase-Programmable Channel Clock Divider

This block is one output channel of a clock distribution tree. It divides a fast timebase by a programmable integer ratio and shifts the divided clock by a programmable number of half source periods. The block's clock `clk_i` runs at twice the rate of the source clock it stands for, so one `clk_i` cycle is one half source period. A ratio of N therefore gives an output period of 2N `clk_i` cycles, with N high and N low. The duty cycle is 50% for every ratio, odd ones included.

A one-cycle pulse on `sync_i` restarts the divider. The divided signal goes low, waits for the programmed phase offset, and then runs from the start of its low half. Each channel can invert its output, can be told to ignore sync pulses, and can be powered down. While it is powered down the output is held low.

The 24-bit configuration word is applied live, but a new ratio or inversion only becomes active at the next accepted sync or at the end of the current output period. Because of this, a configuration write never cuts an output phase short.

Top module: `chdiv_top`

## Requirements
- R1: Bits 17:8 of `cfg_i` hold the ratio minus one. With ratio N active and the divider running, the uninverted output repeats N low cycles followed by N high cycles of `clk_i`, for every N, odd or even.
- R2: The ratio field spans 1 to 1024. Field value 1023 gives a 2048-cycle period, and field value 0 gives an output that toggles every cycle.
- R3: A `sync_i` high at a rising edge, with bit 6 clear, restarts the divider at that edge. From the next cycle the uninverted output is low.
- R4: Bits 23:18 hold a phase offset P (0 to 63) in `clk_i` cycles. After an accepted sync with ratio N, the uninverted output stays low for exactly P+N cycles before its first high half.
- R5: Bit 7 inverts the divided output.
- R6: While bit 6 is set, `sync_i` has no effect on the output sequence.
- R7: While bit 5 is set, `clk_o` is low from the cycle after the edge that samples it. The divider keeps counting, so clearing the bit resumes the running sequence.
- R8: A changed ratio or inversion bit takes effect only at an accepted sync or at the end of the current output period, never partway through one.
- R9: Synchronous active-high reset leaves `clk_o` low, with ratio 1, no inversion and no phase delay active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timebase at twice the source clock rate |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_i | input | 24 | Channel configuration word |
| sync_i | input | 1 | Divider realignment request, one cycle wide |
| clk_o | output | 1 | Divided, phase-shifted channel clock |

## Verification
The divider is run at ratios 1, 3, 4, 5 and 1024. Running odd and even ratios shows that the high and low halves stay equal, and the two extreme ratios exercise the wrap point at both ends of the field. Sync pulses are given with phase offsets 0, 9 and 63. One directed measurement of the first low stretch separates the phase delay from the divider's own low half. A ratio change made mid-period, sync pulses given while the ignore bit is set, and a sync given during power-down show whether the config-update rule, the ignore bit and the power-down gate leave the count itself undisturbed.

// File: rtl/chdiv_pkg.sv
`timescale 1ns/1ps
package chdiv_pkg;
    localparam int DIV_W   = 10;
    localparam int PHASE_W = 6;
    localparam int DRV_W   = 5;
    localparam int CFG_W   = PHASE_W + DIV_W + 3 + DRV_W;

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic [DIV_W-1:0]   ratio_m1;
        logic               invert;
        logic               ign_sync;
        logic               pwr_dn;
        logic [DRV_W-1:0]   drv_mode;
    } chan_cfg_t;

    // last position of a full output period of 2*(m1+1) cycles
    function automatic logic [DIV_W:0] last_pos(input logic [DIV_W-1:0] m1);
        return {m1, 1'b1};
    endfunction
endpackage

// File: rtl/chdiv_phase_delay.sv
`timescale 1ns/1ps
module chdiv_phase_delay #(
    parameter int PHASE_W = 6
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               load_i,
    input  logic [PHASE_W-1:0] load_val_i,
    output logic               busy_o
);
    logic [PHASE_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

    assert_phase_load_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_i && load_val_i != '0) |=> busy_o)
        else $error("phase delay not armed");

    assert_phase_step_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1))
        else $error("phase delay did not step by one");
endmodule

// File: rtl/chdiv_cycle_counter.sv
`timescale 1ns/1ps
module chdiv_cycle_counter
    import chdiv_pkg::*;
#(
    parameter int CW = DIV_W
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          restart_i,
    input  logic          hold_i,
    input  logic [CW-1:0] ratio_m1_i,
    output logic          wrap_o,
    output logic          div_hi_o
);
    logic [CW:0] pos_q;

    assign wrap_o   = !hold_i && (pos_q == last_pos(ratio_m1_i));
    assign div_hi_o = !hold_i && (pos_q > {1'b0, ratio_m1_i});

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i)
            pos_q <= '0;
        else if (hold_i)
            pos_q <= pos_q;
        else if (wrap_o)
            pos_q <= '0;
        else
            pos_q <= pos_q + 1'b1;
    end

    assert_wrap_zero_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (wrap_o || restart_i) |=> (pos_q == '0))
        else $error("counter did not return to zero");

    assert_hold_stable_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (hold_i && !restart_i) |=> $stable(pos_q))
        else $error("counter moved during phase delay");
endmodule

// File: rtl/chdiv_out_stage.sv
`timescale 1ns/1ps
module chdiv_out_stage (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pwr_dn_i,
    input  logic invert_i,
    input  logic div_hi_i,
    output logic clk_o
);
    logic pd_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            pd_q <= 1'b0;
        else
            pd_q <= pwr_dn_i;
    end

    assign clk_o = !pd_q && (invert_i ^ div_hi_i);

    assert_pd_low_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        pwr_dn_i |=> !clk_o)
        else $error("output active while powered down");
endmodule

// File: rtl/chdiv_top.sv
`timescale 1ns/1ps
module chdiv_top
    import chdiv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             sync_i,
    output logic             clk_o
);
    chan_cfg_t        cfg;
    logic [DIV_W-1:0] act_m1_q;
    logic             act_inv_q;
    logic             sync_acc;
    logic             busy;
    logic             wrap;
    logic             div_hi;
    logic             drv_unused;

    assign cfg        = chan_cfg_t'(cfg_i);
    assign drv_unused = ^cfg.drv_mode;
    assign sync_acc   = sync_i && !cfg.ign_sync;

    // active ratio and inversion switch only at sync or period end
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            act_m1_q  <= '0;
            act_inv_q <= 1'b0;
        end else if (sync_acc || wrap) begin
            act_m1_q  <= cfg.ratio_m1;
            act_inv_q <= cfg.invert;
        end
    end

    chdiv_phase_delay #(.PHASE_W(PHASE_W)) u_delay (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (sync_acc),
        .load_val_i (cfg.phase),
        .busy_o     (busy)
    );

    chdiv_cycle_counter #(.CW(DIV_W)) u_count (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .restart_i  (sync_acc),
        .hold_i     (busy),
        .ratio_m1_i (act_m1_q),
        .wrap_o     (wrap),
        .div_hi_o   (div_hi)
    );

    chdiv_out_stage u_out (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .pwr_dn_i (cfg.pwr_dn),
        .invert_i (act_inv_q),
        .div_hi_i (div_hi),
        .clk_o    (clk_o)
    );

    assert_sync_low_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        sync_acc |=> !div_hi)
        else $error("divider not low after sync");

    assert_cfg_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!sync_acc && !wrap) |=> ($stable(act_m1_q) && $stable(act_inv_q)))
        else $error("active config changed mid-period");

    assert_ignore_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg.ign_sync && !wrap) |=> $stable(act_m1_q))
        else $error("ignored sync changed the ratio");
endmodule

// File: tb/chdiv_top_tb_top.sv
`timescale 1ns/1ps
module chdiv_top_tb_top;
    logic        clk;
    logic        rst;
    logic [23:0] cfg;
    logic        sync;
    logic        clk_o;

    int    checks = 0;
    int    errors = 0;
    int    cyc    = 0;
    bit    cmp_en = 0;
    string cur_req = "R9";

    // behavioural reference state
    int m_pos = 0, m_dly = 0, m_m1 = 0;
    bit m_inv = 0, m_pd = 0;

    chdiv_top dut_i (
        .clk_i  (clk),
        .rst_i  (rst),
        .cfg_i  (cfg),
        .sync_i (sync),
        .clk_o  (clk_o)
    );

    initial begin
        clk = 0;
        forever #10 clk = ~clk;
    end

    function automatic logic [23:0] mk_cfg(int ph, int ratio, bit inv, bit ign, bit pd);
        logic [23:0] w;
        w = '0;
        w[23:18] = ph[5:0];
        w[17:8]  = 10'(ratio - 1);
        w[7]     = inv;
        w[6]     = ign;
        w[5]     = pd;
        return w;
    endfunction

    function automatic bit model_out();
        bit hi;
        hi = (m_dly == 0) && (m_pos >= m_m1 + 1);
        return !m_pd && (m_inv ^ hi);
    endfunction

    task automatic check(int act, int exp, string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_pos = 0; m_dly = 0; m_m1 = 0; m_inv = 0; m_pd = 0;
        end else begin
            if (sync && !cfg[6]) begin
                m_m1 = int'(cfg[17:8]); m_inv = cfg[7];
                m_dly = int'(cfg[23:18]); m_pos = 0;
            end else if (m_dly > 0) begin
                m_dly--;
            end else if (m_pos == 2 * m_m1 + 1) begin
                m_pos = 0; m_m1 = int'(cfg[17:8]); m_inv = cfg[7];
            end else begin
                m_pos++;
            end
            m_pd = cfg[5];
        end
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    always @(negedge clk)
        if (cmp_en) check(int'(clk_o), int'(model_out()), cur_req);

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sync();
        @(negedge clk) sync = 1;
        @(negedge clk) sync = 0;
    endtask

    initial begin
        int lows;
        rst = 1; cfg = '0; sync = 0;
        run(3);
        check(int'(clk_o), 0, "R9");           // R9 output low in reset
        rst = 0;
        cmp_en = 1;
        cur_req = "R9"; run(6);
        cur_req = "R1";
        cfg = mk_cfg(0, 3, 0, 0, 0); run(60);
        cfg = mk_cfg(0, 4, 0, 0, 0); run(60);
        cfg = mk_cfg(0, 5, 0, 0, 0); run(80);
        cur_req = "R8";
        run(3); cfg = mk_cfg(0, 7, 0, 0, 0); run(100);
        cur_req = "R3";
        cfg = mk_cfg(0, 3, 0, 0, 0); run(2); pulse_sync(); run(40);
        cur_req = "R4";
        cfg = mk_cfg(9, 6, 0, 0, 0); run(5); pulse_sync();
        lows = 0;
        while (clk_o == 0 && lows < 200) begin
            lows++;
            @(negedge clk);
        end
        check(lows, 15, "R4");                  // R4 P+N low cycles
        run(40);
        cfg = mk_cfg(63, 2, 0, 0, 0); pulse_sync(); run(200);
        cur_req = "R5";
        cfg = mk_cfg(0, 3, 1, 0, 0); pulse_sync(); run(40);
        cfg = mk_cfg(0, 3, 0, 0, 0); run(40);
        cur_req = "R6";
        cfg = mk_cfg(7, 5, 0, 1, 0); run(4); pulse_sync(); run(7); pulse_sync(); run(40);
        cur_req = "R7";
        cfg = mk_cfg(0, 4, 0, 0, 1); run(30); pulse_sync(); run(20);
        cfg = mk_cfg(0, 4, 0, 0, 0); run(40);
        cur_req = "R2";
        cfg = mk_cfg(0, 1024, 0, 0, 0); pulse_sync(); run(4300);
        cfg = mk_cfg(0, 1, 0, 0, 0); pulse_sync(); run(20);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule